// File: doc/BRIEF.md
# Timed Square-Wave Pin Unit

This block owns one chip pin that serves either as a timed square-wave output or as an event input. In output mode, software writes an absolute start time and a half-period, both in ticks of the free-running hardware time counter, and then issues a start strobe. The strobe is accepted only if the start time is still ahead of the counter. From the moment the counter reaches the start time, the pin toggles once per half-period and gives a 50% duty square wave. Edge times are computed as start plus whole multiples of the half-period, so the phase stays tied to the time base even when the counter advances by more than one per cycle. A stop strobe ends the wave and parks the pin low.

In capture mode, the output driver is released. A rising edge arriving on the pin is synchronised and stamps the full time counter into a single capture register, which software polls. The register holds only the newest event. A value of zero means nothing has been seen since reset.

Top module: `ppo_pin_unit`

## Requirements
- R1: After reset, pin_out is 0, running is 0, capture_ts is 0, and with capture_mode low pin_oe is 1.
- R2: A start strobe is accepted (running becomes 1 after the next clock edge) only when start_time is strictly greater than the clk_now sampled on that edge. A start_time equal to or below clk_now leaves running and pin_out unchanged.
- R3: After an accepted start, pin_out stays 0 until the first clock edge at which clk_now is greater than or equal to start_time. On that edge pin_out becomes 1.
- R4: Each later toggle is due at the previous due time plus half_period, counting from start_time. The pin inverts on the first edge at which clk_now has reached the due time, with at most one toggle per cycle. half_period is read when each toggle happens.
- R5: A stop strobe clears running and drives pin_out to 0 after the next edge. When stop and start arrive in the same cycle, stop wins.
- R6: While capture_mode is 1, pin_oe and pin_out are 0. After the next edge running is 0, and start strobes are ignored.
- R7: In capture mode, a rising edge on pin_in passes through a two-flop synchroniser. On the third clock edge after pin_in goes high, capture_ts loads the clk_now value sampled at that edge.
- R8: capture_ts keeps only the newest event: a later rising edge overwrites it. Falling edges, and any pin_in activity while capture_mode is 0, leave it unchanged.
- R9: capture_ts reads 0 until the first captured event after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_now | input | 64 | Current value of the hardware time counter, in ticks |
| start_time | input | 64 | Absolute tick of the first rising edge |
| half_period | input | 32 | Ticks between successive pin edges |
| start_cmd | input | 1 | One-cycle strobe that arms the wave |
| stop_cmd | input | 1 | One-cycle strobe that halts the wave |
| capture_mode | input | 1 | 1 selects event capture, 0 selects wave output |
| pin_in | input | 1 | Pin level seen from outside (capture mode) |
| pin_out | output | 1 | Pin drive value |
| pin_oe | output | 1 | Pin driver enable |
| running | output | 1 | Wave is armed or toggling |
| capture_ts | output | 64 | Time counter value at the newest captured edge |

## Verification
The hardest case to reach from the ports is a toggle whose due time falls between two counter samples. In that case, only exact accumulation from the start time keeps later edges in phase. The bench creates it by making the counter advance by three ticks per cycle with an odd half-period, and a behavioural model predicts each edge from start plus k half-periods. It also creates the start-time boundary by computing start_time from the counter value the next edge will sample, both equal to it and one tick ahead of it.

// File: rtl/ppo_pkg.sv
`timescale 1ns/1ps
package ppo_pkg;
  parameter int PPO_TS_W = 64;
  parameter int PPO_HP_W = 32;
  parameter int PPO_SYNC = 2;

  typedef logic [PPO_TS_W-1:0] ts_t;
  typedef logic [PPO_HP_W-1:0] hp_t;

  // Start is valid only if it lies strictly ahead of the counter.
  function automatic logic start_in_future(ts_t st, ts_t now);
    return st > now;
  endfunction

  // A scheduled edge is due once the counter has reached or passed it.
  function automatic logic edge_reached(ts_t now, ts_t due_at);
    return now >= due_at;
  endfunction

  // Next due time is exact: previous due time plus one half-period.
  function automatic ts_t advance_edge(ts_t due_at, hp_t hp);
    return due_at + ts_t'(hp);
  endfunction
endpackage

// File: rtl/ppo_sched.sv
`timescale 1ns/1ps
module ppo_sched
  import ppo_pkg::*;
#(
  parameter int TS_W = PPO_TS_W,
  parameter int HP_W = PPO_HP_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] now,
  input  logic [TS_W-1:0] start_time,
  input  logic [HP_W-1:0] half_period,
  input  logic            start_cmd,
  input  logic            stop_cmd,
  input  logic            hold,
  output logic            level,
  output logic            running,
  output logic [TS_W-1:0] next_edge,
  output logic            start_accept,
  output logic            edge_due
);
  assign start_accept = start_cmd && !stop_cmd && !hold &&
                        start_in_future(start_time, now);
  assign edge_due     = running && edge_reached(now, next_edge);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      level     <= 1'b0;
      next_edge <= '0;
    end else if (stop_cmd || hold) begin
      running <= 1'b0;
      level   <= 1'b0;
    end else if (start_accept) begin
      running   <= 1'b1;
      level     <= 1'b0;
      next_edge <= start_time;
    end else if (edge_due) begin
      level     <= ~level;
      next_edge <= advance_edge(next_edge, half_period);
    end
  end
endmodule

// File: rtl/ppo_capture.sv
`timescale 1ns/1ps
module ppo_capture
  import ppo_pkg::*;
#(
  parameter int TS_W  = PPO_TS_W,
  parameter int STAGES = PPO_SYNC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] now,
  input  logic            enable,
  input  logic            pin_in,
  output logic            cap_event,
  output logic [TS_W-1:0] stamp
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin_in;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pin_in};
    end
  endgenerate

  assign cap_event = enable && sync_q[TOP] && !prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      stamp  <= '0;
    end else begin
      prev_q <= sync_q[TOP];
      if (cap_event) stamp <= now;
    end
  end
endmodule

// File: rtl/ppo_pin_unit.sv
`timescale 1ns/1ps
module ppo_pin_unit
  import ppo_pkg::*;
#(
  parameter int TS_W   = PPO_TS_W,
  parameter int HP_W   = PPO_HP_W,
  parameter int STAGES = PPO_SYNC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] clk_now,
  input  logic [TS_W-1:0] start_time,
  input  logic [HP_W-1:0] half_period,
  input  logic            start_cmd,
  input  logic            stop_cmd,
  input  logic            capture_mode,
  input  logic            pin_in,
  output logic            pin_out,
  output logic            pin_oe,
  output logic            running,
  output logic [TS_W-1:0] capture_ts
);
  logic            wave_level;
  logic [TS_W-1:0] next_edge;
  logic            start_accept;
  logic            edge_due;
  logic            cap_event;

  ppo_sched #(.TS_W(TS_W), .HP_W(HP_W)) u_sched (
    .clk(clk), .rst_n(rst_n), .now(clk_now), .start_time(start_time),
    .half_period(half_period), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .hold(capture_mode), .level(wave_level), .running(running),
    .next_edge(next_edge), .start_accept(start_accept), .edge_due(edge_due)
  );

  ppo_capture #(.TS_W(TS_W), .STAGES(STAGES)) u_cap (
    .clk(clk), .rst_n(rst_n), .now(clk_now), .enable(capture_mode),
    .pin_in(pin_in), .cap_event(cap_event), .stamp(capture_ts)
  );

  assign pin_oe  = !capture_mode;
  assign pin_out = wave_level && !capture_mode;
endmodule

// File: rtl/ppo_pin_unit_chk.sv
`timescale 1ns/1ps
module ppo_pin_unit_chk #(
  parameter int TS_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic [TS_W-1:0] clk_now,
  input logic [TS_W-1:0] start_time,
  input logic            start_cmd,
  input logic            stop_cmd,
  input logic            capture_mode,
  input logic            running,
  input logic            pin_out,
  input logic            wave_level,
  input logic            edge_due,
  input logic [TS_W-1:0] capture_ts
);
  AST_PAST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && !running && start_time <= clk_now) |=> !running); // R2

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !pin_out); // R3

  AST_NO_EARLY_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !edge_due && !start_cmd && !stop_cmd && !capture_mode)
      |=> $stable(wave_level)); // R4

  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cmd |=> (!running && !pin_out)); // R5

  AST_CAPTURE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    capture_mode |=> !running); // R6

  AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_mode |=> $stable(capture_ts)); // R8
endmodule

bind ppo_pin_unit ppo_pin_unit_chk #(.TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_now(clk_now), .start_time(start_time),
  .start_cmd(start_cmd), .stop_cmd(stop_cmd), .capture_mode(capture_mode),
  .running(running), .pin_out(pin_out), .wave_level(wave_level),
  .edge_due(edge_due), .capture_ts(capture_ts)
);

// File: tb/ppo_pin_unit_test.sv
`timescale 1ns/1ps
module ppo_pin_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] now_v = 64'd100;
  logic [63:0] step = 64'd1;
  logic [63:0] start_time = '0;
  logic [31:0] half_period = 32'd5;
  logic        start_cmd = 1'b0, stop_cmd = 1'b0, capture_mode = 1'b0, pin_in = 1'b0;
  logic        pin_out, pin_oe, running;
  logic [63:0] capture_ts;

  int tests = 0, fails = 0;
  bit cmp_en = 0;

  // behavioural reference state
  bit          m_run, m_lvl, m_s1, m_s2, m_p;
  logic [63:0] m_due, m_cap;

  always #2.5 clk = ~clk;

  ppo_pin_unit uut (
    .clk(clk), .rst_n(rst_n), .clk_now(clk_now_w), .start_time(start_time),
    .half_period(half_period), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .capture_mode(capture_mode), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .running(running), .capture_ts(capture_ts)
  );
  wire [63:0] clk_now_w = now_v;

  always @(negedge clk) if (rst_n) now_v <= now_v + step;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_lvl = 0; m_due = 0; m_cap = 0; m_s1 = 0; m_s2 = 0; m_p = 0;
    end else begin
      if (capture_mode && m_s2 && !m_p) m_cap = clk_now_w;
      m_p = m_s2; m_s2 = m_s1; m_s1 = pin_in;
      if (stop_cmd || capture_mode) begin
        m_run = 0; m_lvl = 0;
      end else if (start_cmd && start_time > clk_now_w) begin
        m_run = 1; m_lvl = 0; m_due = start_time;
      end else if (m_run && clk_now_w >= m_due) begin
        m_lvl = !m_lvl; m_due = m_due + {32'd0, half_period};
      end
      #1;
      if (cmp_en) begin
        chk("R3 R4 pin_out vs model", {63'd0, pin_out}, {63'd0, m_lvl && !capture_mode});
        chk("R2 R5 running vs model", {63'd0, running}, {63'd0, m_run});
        chk("R6 pin_oe vs mode", {63'd0, pin_oe}, {63'd0, !capture_mode});
        chk("R7 R8 capture_ts vs model", capture_ts, m_cap);
      end
    end
  end

  task automatic issue(input logic [63:0] st, input bit go, input bit halt);
    @(negedge clk);
    start_time = st; start_cmd = go; stop_cmd = halt;
    @(posedge clk); #1;
    start_cmd = 0; stop_cmd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] v, held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    chk("R1 pin_out after reset", {63'd0, pin_out}, 64'd0);
    chk("R1 running after reset", {63'd0, running}, 64'd0);
    chk("R1 pin_oe after reset", {63'd0, pin_oe}, 64'd1);
    chk("R9 capture_ts zero after reset", capture_ts, 64'd0);
    cmp_en = 1;

    // R2 R3: start in the future, half-period 5
    issue(now_v + 20, 1, 0);
    chk("R2 future start accepted", {63'd0, running}, 64'd1);
    chk("R3 low before start", {63'd0, pin_out}, 64'd0);
    idle(70);
    issue('0, 0, 1);
    chk("R5 stop clears running", {63'd0, running}, 64'd0);
    chk("R5 stop parks pin low", {63'd0, pin_out}, 64'd0);

    // R2 boundary: start equal to sampled counter and in the past
    issue(now_v + step, 1, 0);
    chk("R2 start equal to now ignored", {63'd0, running}, 64'd0);
    issue(now_v - 5, 1, 0);
    chk("R2 past start ignored", {63'd0, running}, 64'd0);
    issue(now_v + step + 1, 1, 0);
    chk("R2 start one tick ahead accepted", {63'd0, running}, 64'd1);
    idle(10);

    // R4: counter steps by 3, odd half-period, exact accumulation
    @(negedge clk); step = 3; half_period = 7;
    issue(now_v + 31, 1, 0);
    chk("R4 rearm with coarse steps", {63'd0, running}, 64'd1);
    idle(60);
    @(negedge clk); half_period = 4;
    idle(30);

    // R5: start and stop together
    issue(now_v + 40, 1, 1);
    chk("R5 stop wins over start", {63'd0, running}, 64'd0);

    // R6: capture mode releases the pin
    issue(now_v + 20, 1, 0);
    @(negedge clk); capture_mode = 1;
    @(posedge clk); #1;
    chk("R6 driver disabled", {63'd0, pin_oe}, 64'd0);
    chk("R6 output forced low", {63'd0, pin_out}, 64'd0);
    chk("R6 running cleared", {63'd0, running}, 64'd0);
    issue(now_v + 50, 1, 0);
    chk("R6 start ignored in capture", {63'd0, running}, 64'd0);
    idle(3);
    chk("R9 no event yet", capture_ts, 64'd0);

    // R7: first capture
    @(negedge clk); v = now_v; pin_in = 1;
    repeat (3) @(posedge clk); #1;
    chk("R7 stamp on third edge", capture_ts, v + 3 * step);
    held = capture_ts;
    idle(4);
    @(negedge clk); pin_in = 0;
    idle(6);
    chk("R8 falling edge ignored", capture_ts, held);

    // R8: overwrite by later event
    @(negedge clk); v = now_v; pin_in = 1;
    repeat (3) @(posedge clk); #1;
    chk("R8 newer event overwrites", capture_ts, v + 3 * step);
    held = capture_ts;
    @(negedge clk); pin_in = 0;
    idle(4);

    // R8: pin activity in output mode
    @(negedge clk); capture_mode = 0;
    idle(2);
    @(negedge clk); pin_in = 1;
    idle(6);
    @(negedge clk); pin_in = 0;
    idle(4);
    chk("R8 output-mode pin ignored", capture_ts, held);

    idle(5);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule